// File: doc/BRIEF.md
# IR pulse-width capture receiver

This block records one infrared remote-control frame as a list of durations. A demodulated, already-synchronous receiver output enters the block. The block measures how long each burst of carrier lasts and how long each gap between bursts lasts. Each duration is counted in sample periods. One sample period is a programmable number of ticks of an internally divided clock.

Each duration is stored as one byte. The bytes are packed four to a 32-bit word in a bank of words that software can read. The first byte is always a burst. Bytes after it alternate between gap and burst. A level that lasts 255 samples ends the frame and is stored as 0xFF. Running out of byte slots also ends the frame. When the frame ends, the block flags an interrupt and ignores the input until software re-arms it.

Software reads the stored bytes, hands them to a protocol decoder elsewhere, clears the interrupt and writes the restart strobe.

Top module: `irpw_capture`

## Requirements
- R1: After reset the registers read as follows. Offset 0x0C reads 0. Offset 0x10 reads 0x000C0000, which is period 0xC00. Offsets 0xCC and 0xD0 read 0. Every capture word reads 0. `irq` is low.
- R2: Offset 0x0C holds two enables, bit 0 and bit 13, and both read back. Capture runs only while both are 1. With either one at 0, a frame on the input stores nothing and raises no pending flag.
- R3: Offset 0x10 holds the sample-period field P in bits 20:8, and the field reads back. One sample lasts P × 4 clocks, and each stored width is a count of samples.
- R4: The capture bank is 17 words at offsets 0x88 + 4·k, for k = 0 to 16. Stored byte n sits in word n/4, in lane n mod 4. Lane 0 is bits 7:0 and lane 3 is bits 31:24.
- R5: The input is active-low, so 0 means carrier present. Byte 0 is the first burst, and later bytes alternate gap, burst, gap. Input that is idle before the first active sample after re-arming is not recorded.
- R6: A level that lasts 255 samples is stored as 0xFF and ends the frame. A level that lasts 254 samples is stored as 0xFE and capture continues.
- R7: The pending flag is set when a 0xFF is stored or when all 68 slots are full. After that, input changes leave every capture word unchanged until the restart strobe is written.
- R8: Writing 1 to bit 0 of offset 0x20 zeroes all 68 slots and re-arms capture. The pending flag is left unchanged.
- R9: Bit 0 of offset 0xCC is the interrupt enable. Reading offset 0xD0 bit 0 returns the pending flag, and writing 1 to that bit clears it. `irq` equals pending AND enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (divided by 4 internally for sampling) |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 32 | Register read data, combinational from `rd_addr` |
| ir_in | input | 1 | Demodulated receiver output, active-low |
| irq | output | 1 | Interrupt request, pending AND enable |

## Verification
A register write takes effect on the clock edge that samples `wr_en`. Reads are combinational, so the bench reads one cycle after a write and samples 1 ns after the falling edge.

Each width is stored one sample tick after its level ends, and the input passes through two synchroniser flops before that. The bench therefore changes the input only at falling edges, in whole multiples of the sample period counted from the restart strobe. Every level then covers an exact number of sample ticks, and the expected bytes are the programmed durations.

A frame ends 255 samples into the trailing idle level. The bench polls the pending bit once per cycle with a bounded wait instead of predicting that edge. It compares all 17 words only after pending is seen.

// File: rtl/irpw_pkg.sv
package irpw_pkg;

    localparam int REG_AW   = 8;
    localparam int PERIOD_W = 13;

    // Register offsets (software map)
    localparam logic [REG_AW-1:0] OFS_CTRL    = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_PERIOD  = 8'h10;
    localparam logic [REG_AW-1:0] OFS_RESTART = 8'h20;
    localparam logic [REG_AW-1:0] OFS_CAPTURE = 8'h88;
    localparam logic [REG_AW-1:0] OFS_IRQ_EN  = 8'hCC;
    localparam logic [REG_AW-1:0] OFS_IRQ_ACK = 8'hD0;

    localparam int CTRL_IR_BIT = 0;
    localparam int CTRL_PW_BIT = 13;
    localparam int PERIOD_LSB  = 8;

    // Terminal width value: saturated level ends the frame
    localparam logic [7:0] WIDTH_END = 8'hFF;

    typedef enum logic [1:0] {
        CAP_ARMED   = 2'd0,
        CAP_MEASURE = 2'd1,
        CAP_FROZEN  = 2'd2
    } cap_state_e;

    typedef struct packed {
        logic                ir_on;
        logic                pw_on;
        logic [PERIOD_W-1:0] period;
        logic                irq_en;
    } cfg_t;

    // Saturating increment of a width count
    function automatic logic [7:0] width_bump(input logic [7:0] w);
        return (w == 8'hFF) ? w : w + 8'd1;
    endfunction

endpackage

// File: rtl/irpw_sampler.sv
module irpw_sampler
    import irpw_pkg::*;
#(
    parameter int CLK_DIV     = 4,
    parameter bit ACTIVE_HIGH = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run,
    input  logic                restart,
    input  logic [PERIOD_W-1:0] period,
    input  logic                ir_in,
    output logic                tick_o,
    output logic                active_o
);

    localparam int   DIV_W    = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic IDLE_LVL = ACTIVE_HIGH ? 1'b0 : 1'b1;

    // Two-flop synchroniser, reset to the idle level
    logic [1:0] sync_q;
    always_ff @(posedge clk) begin
        if (rst) sync_q <= {2{IDLE_LVL}};
        else     sync_q <= {sync_q[0], ir_in};
    end

    generate
        if (ACTIVE_HIGH) begin : g_act_hi
            assign active_o = sync_q[1];
        end else begin : g_act_lo
            assign active_o = ~sync_q[1];
        end
    endgenerate

    // Clock divider and sample-period counter; a zero period acts as one
    logic [DIV_W-1:0]    div_q;
    logic [PERIOD_W-1:0] per_q;
    logic [PERIOD_W-1:0] per_last;
    logic                div_wrap;
    logic                per_wrap;

    assign per_last = (period == '0) ? '0 : period - PERIOD_W'(1);
    assign div_wrap = (div_q == DIV_W'(CLK_DIV - 1));
    assign per_wrap = (per_q >= per_last);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            div_q <= '0;
            per_q <= '0;
        end else if (div_wrap) begin
            div_q <= '0;
            per_q <= per_wrap ? '0 : per_q + PERIOD_W'(1);
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    assign tick_o = run && div_wrap && per_wrap;

endmodule

// File: rtl/irpw_engine.sv
module irpw_engine
    import irpw_pkg::*;
#(
    parameter int NUM_SLOTS = 68,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              tick,
    input  logic              active,
    output logic              wr_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic [7:0]        width_o,
    output logic              done_o
);

    cap_state_e        state_q, state_d;
    logic              lvl_q, lvl_d;     // 1: measuring a burst, 0: a gap
    logic [7:0]        cnt_q, cnt_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic              same;
    logic [7:0]        cnt_inc;

    assign same    = (active == lvl_q);
    assign cnt_inc = width_bump(cnt_q);
    assign slot_o  = slot_q;

    always_comb begin
        state_d = state_q;
        lvl_d   = lvl_q;
        cnt_d   = cnt_q;
        slot_d  = slot_q;
        wr_o    = 1'b0;
        width_o = cnt_q;
        done_o  = 1'b0;
        if (tick) begin
            unique case (state_q)
                CAP_ARMED: begin
                    if (active) begin
                        state_d = CAP_MEASURE;
                        lvl_d   = 1'b1;
                        cnt_d   = 8'd1;
                    end
                end
                CAP_MEASURE: begin
                    if (same) begin
                        if (cnt_inc == WIDTH_END) begin
                            wr_o    = 1'b1;
                            width_o = WIDTH_END;
                            done_o  = 1'b1;
                            state_d = CAP_FROZEN;
                        end else begin
                            cnt_d = cnt_inc;
                        end
                    end else begin
                        wr_o    = 1'b1;
                        width_o = cnt_q;
                        if (slot_q == SLOT_W'(NUM_SLOTS - 1)) begin
                            done_o  = 1'b1;
                            state_d = CAP_FROZEN;
                        end else begin
                            slot_d = slot_q + SLOT_W'(1);
                            lvl_d  = ~lvl_q;
                            cnt_d  = 8'd1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            state_q <= CAP_ARMED;
            lvl_q   <= 1'b0;
            cnt_q   <= '0;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_d;
            cnt_q   <= cnt_d;
            slot_q  <= slot_d;
        end
    end

    // R4
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        wr_o |-> (int'(slot_o) < NUM_SLOTS));

    // R5
    width_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        wr_o |-> (width_o != 8'h00));

    // R7
    frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == CAP_FROZEN && !restart) |=> (state_q == CAP_FROZEN));

    // R7
    frozen_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == CAP_FROZEN) |-> !wr_o);

endmodule

// File: rtl/irpw_store.sv
module irpw_store
    import irpw_pkg::*;
#(
    parameter int NUM_WORDS = 17,
    parameter int SLOT_W    = $clog2(NUM_WORDS * 4),
    parameter int WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              wr_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [7:0]        width_i,
    input  logic [WORD_W-1:0] rd_word_i,
    output logic [31:0]       rd_data_o
);

    logic [31:0] word_w [NUM_WORDS];

    generate
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
            logic [3:0][7:0] lane_q;
            always_ff @(posedge clk) begin
                if (rst || clear) begin
                    lane_q <= '0;
                end else if (wr_i && (slot_i[SLOT_W-1:2] == (SLOT_W-2)'(w))) begin
                    lane_q[slot_i[1:0]] <= width_i;
                end
            end
            assign word_w[w] = lane_q;
        end
    endgenerate

    assign rd_data_o = (int'(rd_word_i) < NUM_WORDS) ? word_w[rd_word_i] : '0;

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (word_w[0] == '0 && word_w[NUM_WORDS-1] == '0));

endmodule

// File: rtl/irpw_capture.sv
module irpw_capture
    import irpw_pkg::*;
#(
    parameter int                  CLK_DIV     = 4,
    parameter int                  NUM_WORDS   = 17,
    parameter bit                  ACTIVE_HIGH = 1'b0,
    parameter logic [PERIOD_W-1:0] PERIOD_RST  = 13'hC00
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic              ir_in,
    output logic              irq
);

    localparam int NUM_SLOTS = NUM_WORDS * 4;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int WORD_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int CAP_SPAN  = 4 * NUM_WORDS;

    // ---------------- register file ----------------
    cfg_t cfg_q;
    logic pend_q;
    logic wr_ctrl, wr_period, wr_ien, ack_wr, restart;
    logic run;

    assign wr_ctrl   = wr_en && (wr_addr == OFS_CTRL);
    assign wr_period = wr_en && (wr_addr == OFS_PERIOD);
    assign wr_ien    = wr_en && (wr_addr == OFS_IRQ_EN);
    assign ack_wr    = wr_en && (wr_addr == OFS_IRQ_ACK) && wr_data[0];
    assign restart   = wr_en && (wr_addr == OFS_RESTART) && wr_data[0];
    assign run       = cfg_q.ir_on && cfg_q.pw_on;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{ir_on: 1'b0, pw_on: 1'b0, period: PERIOD_RST, irq_en: 1'b0};
        end else begin
            if (wr_ctrl) begin
                cfg_q.ir_on <= wr_data[CTRL_IR_BIT];
                cfg_q.pw_on <= wr_data[CTRL_PW_BIT];
            end
            if (wr_period) cfg_q.period <= wr_data[PERIOD_LSB +: PERIOD_W];
            if (wr_ien)    cfg_q.irq_en <= wr_data[0];
        end
    end

    // ---------------- capture datapath ----------------
    logic              tick, active;
    logic              cap_wr, cap_done;
    logic [SLOT_W-1:0] cap_slot;
    logic [7:0]        cap_width;

    irpw_sampler #(
        .CLK_DIV     (CLK_DIV),
        .ACTIVE_HIGH (ACTIVE_HIGH)
    ) u_sampler (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .restart  (restart),
        .period   (cfg_q.period),
        .ir_in    (ir_in),
        .tick_o   (tick),
        .active_o (active)
    );

    irpw_engine #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_W    (SLOT_W)
    ) u_engine (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick    (tick),
        .active  (active),
        .wr_o    (cap_wr),
        .slot_o  (cap_slot),
        .width_o (cap_width),
        .done_o  (cap_done)
    );

    // Pending flag: completion wins over a same-cycle acknowledge
    always_ff @(posedge clk) begin
        if (rst)           pend_q <= 1'b0;
        else if (cap_done) pend_q <= 1'b1;
        else if (ack_wr)   pend_q <= 1'b0;
    end

    assign irq = pend_q & cfg_q.irq_en;

    // ---------------- read path ----------------
    logic [REG_AW-1:0] cap_off;
    logic              cap_hit;
    logic [WORD_W-1:0] cap_word;
    logic [31:0]       cap_data;

    assign cap_off  = rd_addr - OFS_CAPTURE;
    assign cap_hit  = (rd_addr >= OFS_CAPTURE) && (cap_off < REG_AW'(CAP_SPAN))
                      && (cap_off[1:0] == 2'b00);
    assign cap_word = cap_off[2 +: WORD_W];

    irpw_store #(
        .NUM_WORDS (NUM_WORDS),
        .SLOT_W    (SLOT_W),
        .WORD_W    (WORD_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .clear     (restart),
        .wr_i      (cap_wr),
        .slot_i    (cap_slot),
        .width_i   (cap_width),
        .rd_word_i (cap_word),
        .rd_data_o (cap_data)
    );

    always_comb begin
        rd_data = '0;
        if (cap_hit) begin
            rd_data = cap_data;
        end else begin
            case (rd_addr)
                OFS_CTRL: begin
                    rd_data[CTRL_IR_BIT] = cfg_q.ir_on;
                    rd_data[CTRL_PW_BIT] = cfg_q.pw_on;
                end
                OFS_PERIOD:  rd_data[PERIOD_LSB +: PERIOD_W] = cfg_q.period;
                OFS_IRQ_EN:  rd_data[0] = cfg_q.irq_en;
                OFS_IRQ_ACK: rd_data[0] = pend_q;
                default: ;
            endcase
        end
    end

    // R7
    pend_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(cap_done));

    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (ack_wr && !cap_done) |=> !pend_q);

endmodule

// File: tb/irpw_capture_bench.sv
`timescale 1ns/1ps
module irpw_capture_bench;
    import irpw_pkg::*;

    localparam int P = 2;
    localparam int S = 4 * P;          // clocks per sample
    localparam int NV = 4;
    localparam int VEC_N [NV] = '{3, 5, 7, 1};
    localparam logic [7:0] VEC_W [NV][8] = '{
        '{8'd5,  8'd3, 8'd7,  8'd0, 8'd0,  8'd0, 8'd0,  8'd0},
        '{8'd1,  8'd2, 8'd1,  8'd2, 8'd1,  8'd0, 8'd0,  8'd0},
        '{8'd10, 8'd4, 8'd10, 8'd4, 8'd10, 8'd4, 8'd20, 8'd0},
        '{8'd12, 8'd0, 8'd0,  8'd0, 8'd0,  8'd0, 8'd0,  8'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        ir_in = 1'b1;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irpw_capture u_irpw_capture (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .ir_in   (ir_in),
        .irq     (irq)
    );

    task automatic check32(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic hold(input logic lvl, input int samples);
        ir_in = lvl;
        repeat (samples * S) @(negedge clk);
    endtask

    task automatic wait_pend(input int limit, output bit got);
        logic [31:0] d;
        got = 1'b0;
        for (int i = 0; i < limit; i++) begin
            reg_rd(OFS_IRQ_ACK, d);
            if (d[0]) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    task automatic check_bank(input string req, input logic [7:0] es [68]);
        logic [31:0] d;
        for (int w = 0; w < 17; w++) begin
            reg_rd(8'(8'h88 + 4 * w), d);
            check32(req, $sformatf("word %0d", w), d,
                    {es[4*w+3], es[4*w+2], es[4*w+1], es[4*w]});
        end
    endtask

    task automatic rearm();
        reg_wr(OFS_RESTART, 32'h1);
        reg_wr(OFS_IRQ_ACK, 32'h1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin : watchdog
        #(150000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic [7:0]  es [68];
        bit          got;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        reg_rd(OFS_CTRL, d);    check32("R1", "ctrl", d, 32'h0);
        reg_rd(OFS_PERIOD, d);  check32("R1", "period", d, 32'h000C0000);
        reg_rd(OFS_IRQ_EN, d);  check32("R1", "irq enable", d, 32'h0);
        reg_rd(OFS_IRQ_ACK, d); check32("R1", "pending", d, 32'h0);
        reg_rd(8'h88, d);       check32("R1", "word 0", d, 32'h0);
        reg_rd(8'hC8, d);       check32("R1", "word 16", d, 32'h0);
        check32("R1", "irq", {31'b0, irq}, 32'h0);

        // R2 R3 R9 configuration readback
        reg_wr(OFS_CTRL, 32'h2001);
        reg_rd(OFS_CTRL, d);   check32("R2", "ctrl readback", d, 32'h2001);
        reg_wr(OFS_PERIOD, 32'(P) << 8);
        reg_rd(OFS_PERIOD, d); check32("R3", "period readback", d, 32'(P) << 8);
        reg_wr(OFS_IRQ_EN, 32'h1);
        reg_rd(OFS_IRQ_EN, d); check32("R9", "enable readback", d, 32'h1);

        // R4 R5 R6 R7 table of frames
        for (int v = 0; v < NV; v++) begin
            rearm();
            hold(1'b1, 3 + v);
            for (int i = 0; i < VEC_N[v]; i++)
                hold((i % 2 == 0) ? 1'b0 : 1'b1, int'(VEC_W[v][i]));
            ir_in = 1'b1;
            wait_pend(300 * S, got);
            check32("R7", $sformatf("vector %0d pending", v), {31'b0, got}, 32'h1);
            check32("R9", $sformatf("vector %0d irq", v), {31'b0, irq}, 32'h1);
            for (int k = 0; k < 68; k++) es[k] = 8'h00;
            for (int k = 0; k < VEC_N[v]; k++) es[k] = VEC_W[v][k];
            es[VEC_N[v]] = WIDTH_END;
            check_bank($sformatf("R4 R5 R6 vector %0d", v), es);
        end

        // R7 frozen: input after frame end is ignored
        hold(1'b0, 5);
        hold(1'b1, 3);
        reg_rd(8'h88, d); check32("R7", "frozen word 0", d, 32'h0000FF0C);

        // R8 restart zeroes the bank, pending kept
        reg_wr(OFS_RESTART, 32'h1);
        for (int k = 0; k < 68; k++) es[k] = 8'h00;
        check_bank("R8", es);
        reg_rd(OFS_IRQ_ACK, d); check32("R8", "pending kept", d, 32'h1);

        // R9 interrupt gating and acknowledge
        reg_wr(OFS_IRQ_EN, 32'h0);
        check32("R9", "irq masked", {31'b0, irq}, 32'h0);
        reg_wr(OFS_IRQ_EN, 32'h1);
        check32("R9", "irq unmasked", {31'b0, irq}, 32'h1);
        reg_wr(OFS_IRQ_ACK, 32'h1);
        check32("R9", "irq after ack", {31'b0, irq}, 32'h0);
        reg_rd(OFS_IRQ_ACK, d); check32("R9", "pending after ack", d, 32'h0);

        // R5 long idle before the first burst is not recorded
        rearm();
        hold(1'b1, 300);
        hold(1'b0, 4);
        ir_in = 1'b1;
        wait_pend(300 * S, got);
        check32("R5", "pre-idle pending", {31'b0, got}, 32'h1);
        reg_rd(8'h88, d); check32("R5", "pre-idle word 0", d, 32'h0000FF04);

        // R6 254-sample burst is kept
        rearm();
        hold(1'b0, 254);
        ir_in = 1'b1;
        wait_pend(300 * S, got);
        reg_rd(8'h88, d); check32("R6", "254 samples", d, 32'h0000FFFE);

        // R6 255-sample burst saturates and ends the frame
        rearm();
        hold(1'b0, 260);
        hold(1'b1, 20);
        wait_pend(4, got);
        check32("R6", "saturated pending", {31'b0, got}, 32'h1);
        reg_rd(8'h88, d); check32("R6", "saturated word 0", d, 32'h000000FF);

        // R7 all 68 slots filled, then input ignored
        rearm();
        for (int i = 0; i < 69; i++) hold((i % 2 == 0) ? 1'b0 : 1'b1, 1);
        hold(1'b1, 10);
        hold(1'b0, 3);
        hold(1'b1, 3);
        wait_pend(4, got);
        check32("R7", "full bank pending", {31'b0, got}, 32'h1);
        for (int k = 0; k < 68; k++) es[k] = 8'h01;
        check_bank("R7 full bank", es);

        // R2 capture blocked with either enable clear
        reg_wr(OFS_CTRL, 32'h0001);
        reg_rd(OFS_CTRL, d); check32("R2", "ctrl one bit", d, 32'h0001);
        rearm();
        hold(1'b0, 5);
        hold(1'b1, 270);
        reg_rd(OFS_IRQ_ACK, d); check32("R2", "pw off pending", d, 32'h0);
        reg_rd(8'h88, d);       check32("R2", "pw off word 0", d, 32'h0);
        reg_wr(OFS_CTRL, 32'h2000);
        rearm();
        hold(1'b0, 5);
        hold(1'b1, 270);
        reg_rd(OFS_IRQ_ACK, d); check32("R2", "ir off pending", d, 32'h0);
        reg_rd(8'h88, d);       check32("R2", "ir off word 0", d, 32'h0);
        reg_wr(OFS_CTRL, 32'h2001);

        // R3 period 1: 24 clocks of burst are 6 samples
        reg_wr(OFS_PERIOD, 32'h100);
        rearm();
        ir_in = 1'b0;
        repeat (24) @(negedge clk);
        ir_in = 1'b1;
        wait_pend(300 * 4, got);
        check32("R3", "period 1 pending", {31'b0, got}, 32'h1);
        reg_rd(8'h88, d); check32("R3", "period 1 word 0", d, 32'h0000FF06);

        summary();
        $finish;
    end

endmodule